// File: doc/BRIEF.md
# Three-Channel Gamma Lookup Bank with Host Load Port

This block holds three 256-entry by 8-bit lookup tables, one for red, one for green and one for blue, and places them in the pixel path. On every clock, each incoming colour sample indexes its own table. The table output appears on the matching pixel output one clock later. The usual contents are a gamma curve or a range limit.

A host loads and reads the tables over a 5-bit command address and an 8-bit data bus. The host cannot address table entries directly. Each table has its own entry pointer. One command address sends all three pointers back to zero. Three further command addresses select a colour. An access to a colour uses that colour's pointer and then moves it on by one entry. The pointers stop at the end of the table and do not wrap.

The host strobes are asynchronous. They pass through a synchronizer and an edge detector in the pixel clock domain. If the host and the pixel side want the same table in the same cycle, the host wins, and that channel's pixel output keeps its previous value for that cycle.

Top module: `gamma_lut_bank`

## Requirements
- R1: A host access (read or write strobe) at command address 27 sets all three entry pointers to zero. It touches no table contents.
- R2: A host access at address 28 goes to the red table, 29 to the green table and 30 to the blue table. The access uses that table's entry pointer, and the pointer then increases by one.
- R3: A pointer that has reached 256 stays there. Further accesses to that table are ignored: nothing is written, host_rdata keeps its value and the pixel output is not held. This lasts until address 27 is used again.
- R4: The three pointers are independent, so red, green and blue accesses may be interleaved one byte at a time.
- R5: A read access loads host_rdata with the addressed entry. host_rdata changes at no other time, except at reset.
- R6: A strobe is active while host_cs_n is low together with host_rd_n (read) or host_wr_n (write). Each assertion performs exactly one access. The access happens at the third rising edge at which the active strobe is sampled, using host_addr and host_wdata at that edge. A write strobe must be held for at least 2 clocks and a read strobe for at least 5. Addresses other than 27 to 30 are ignored.
- R7: Each clock, pix_out_r/g/b is loaded with the entry of the red/green/blue table indexed by pix_in_r/g/b. The value appears one clock after the index is presented.
- R8: At a rising edge where a host access is taken by a table, that channel's pixel output keeps its previous value. The other channels update as usual.
- R9: rst_n is an asynchronous active-low reset. It clears the pointers, host_rdata and all pixel outputs to zero, and leaves table contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 5 | Host command address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Last entry read by the host |
| pix_in_r | input | 8 | Red table index |
| pix_in_g | input | 8 | Green table index |
| pix_in_b | input | 8 | Blue table index |
| pix_out_r | output | 8 | Red lookup result |
| pix_out_g | output | 8 | Green lookup result |
| pix_out_b | output | 8 | Blue lookup result |

## Verification
The bench builds the block with its default parameters. These are 8-bit entries, 8-bit indices (full 256-entry tables), a two-flop synchronizer and command addresses 27 to 30. With full-depth tables the bench can reach the exact point where a pointer stops at 256, run an overrun access against it, and read back every entry after an interleaved load of all three colours. The two-flop setting fixes the third-edge access timing that the reference model follows. That timing lets the bench test the shortest legal write strobe and the host-over-pixel collision in known cycles.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int NUM_CH = 3;

   // True when a host command address selects colour channel ch.
   function automatic logic host_hits_chan(input int unsigned addr, input int unsigned base,
                                           input int unsigned ch);
      return addr == base + ch;
   endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_in};
   end

   // one cycle pulse when the synchronized level first goes high
   assign pulse = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lut_channel.sv
module lut_channel #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] pix_idx,
   output logic [DATA_W-1:0] pix_q,
   output logic [DATA_W-1:0] cur_word,
   output logic              grant,
   output logic [ADDR_W:0]   ptr
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              exhausted;

   assign exhausted = ptr[ADDR_W];
   assign grant     = acc & ~exhausted;
   assign cur_word  = mem[ptr[ADDR_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (clr)   ptr <= '0;
      else if (grant) ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (grant && wr) mem[ptr[ADDR_W-1:0]] <= wdata;
   end

   // host owns the single port during a granted cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pix_q <= '0;
      else if (!grant) pix_q <= mem[pix_idx];
   end
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int HOST_AW     = 5,
   parameter int CMD_CLEAR   = 27,
   parameter int CMD_BASE    = 28,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_cs_n,
   input  logic               host_rd_n,
   input  logic               host_wr_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   input  logic [ADDR_W-1:0]  pix_in_r,
   input  logic [ADDR_W-1:0]  pix_in_g,
   input  logic [ADDR_W-1:0]  pix_in_b,
   output logic [DATA_W-1:0]  pix_out_r,
   output logic [DATA_W-1:0]  pix_out_g,
   output logic [DATA_W-1:0]  pix_out_b
);
   import gamma_lut_pkg::*;

   localparam int CW       = ADDR_W + 1;
   localparam int LAST_CMD = CMD_BASE + NUM_CH - 1;

   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("gamma_lut_bank: widths must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gamma_lut_bank: at least two synchronizer stages required");
   end
   if (LAST_CMD >= (1 << HOST_AW) || CMD_CLEAR >= (1 << HOST_AW)) begin : g_bad_cmd
      $error("gamma_lut_bank: command address outside host address space");
   end
   if (CMD_CLEAR >= CMD_BASE && CMD_CLEAR <= LAST_CMD) begin : g_bad_overlap
      $error("gamma_lut_bank: clear command overlaps a channel select");
   end

   logic              wr_pulse, rd_pulse, any_pulse, clr_cmd;
   logic [NUM_CH-1:0] sel, grant;
   logic [ADDR_W-1:0] idx   [NUM_CH];
   logic [DATA_W-1:0] pix_q [NUM_CH];
   logic [DATA_W-1:0] word  [NUM_CH];
   logic [NUM_CH*CW-1:0] cnt_flat;

   strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .async_in(~(host_cs_n | host_wr_n)), .pulse(wr_pulse));
   strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .async_in(~(host_cs_n | host_rd_n)), .pulse(rd_pulse));

   assign any_pulse = wr_pulse | rd_pulse;
   assign clr_cmd   = any_pulse && (host_addr == HOST_AW'(CMD_CLEAR));

   assign idx[0] = pix_in_r;
   assign idx[1] = pix_in_g;
   assign idx[2] = pix_in_b;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      assign sel[ch] = any_pulse && host_hits_chan(int'(host_addr), CMD_BASE, ch);

      lut_channel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lut (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr_cmd),
         .acc     (sel[ch]),
         .wr      (wr_pulse),
         .wdata   (host_wdata),
         .pix_idx (idx[ch]),
         .pix_q   (pix_q[ch]),
         .cur_word(word[ch]),
         .grant   (grant[ch]),
         .ptr     (cnt_flat[ch*CW +: CW])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (rd_pulse && !wr_pulse) begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            if (grant[ch]) host_rdata <= word[ch];
         end
      end
   end

   assign pix_out_r = pix_q[0];
   assign pix_out_g = pix_q[1];
   assign pix_out_b = pix_q[2];
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_pulse,
   input logic                       rd_pulse,
   input logic                       clr_cmd,
   input logic [2:0]                 grant,
   input logic [3*(ADDR_W+1)-1:0]    cnt_flat,
   input logic [DATA_W-1:0]          host_rdata,
   input logic [3*DATA_W-1:0]        pix_flat
);
   localparam int CW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   assert_one_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);
   assert_one_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pulse |=> !rd_pulse);
   assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pulse |=> $stable(host_rdata));

   for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
         clr_cmd |=> cnt_flat[ch*CW +: CW] == '0);
      assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
         grant[ch] |=> cnt_flat[ch*CW +: CW] == $past(cnt_flat[ch*CW +: CW]) + 1'b1);
      assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_flat[ch*CW +: CW] == CW'(DEPTH) && !clr_cmd) |=> cnt_flat[ch*CW +: CW] == CW'(DEPTH));
      assert_pix_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         grant[ch] |=> $stable(pix_flat[ch*DATA_W +: DATA_W]));
   end
endmodule

bind gamma_lut_bank gamma_lut_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_pulse  (wr_pulse),
   .rd_pulse  (rd_pulse),
   .clr_cmd   (clr_cmd),
   .grant     (grant),
   .cnt_flat  (cnt_flat),
   .host_rdata(host_rdata),
   .pix_flat  ({pix_out_b, pix_out_g, pix_out_r})
);

// File: tb/tb_gamma_lut_bank.sv
module tb_gamma_lut_bank;
   localparam int CLK_PERIOD = 10;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       host_cs_n = 1, host_rd_n = 1, host_wr_n = 1;
   logic [4:0] host_addr = 0;
   logic [7:0] host_wdata = 0;
   logic [7:0] host_rdata;
   logic [7:0] pix_in_r = 0, pix_in_g = 0, pix_in_b = 0;
   logic [7:0] pix_out_r, pix_out_g, pix_out_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gamma_lut_bank dut (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
      .host_wr_n(host_wr_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .pix_in_r(pix_in_r), .pix_in_g(pix_in_g),
      .pix_in_b(pix_in_b), .pix_out_r(pix_out_r), .pix_out_g(pix_out_g),
      .pix_out_b(pix_out_b));

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_ram   [3][256];
   bit         m_known [3][256];
   int         m_cnt   [3];
   logic [7:0] m_pix   [3];
   bit         m_pix_k [3];
   logic [7:0] m_rdata;
   int         run_w, run_r;
   bit         pend_w, pend_r;

   initial begin
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < 256; i++) m_known[c][i] = 0;
   end

   function automatic logic [7:0] pix_sel(input int c);
      return (c == 0) ? pix_in_r : (c == 1) ? pix_in_g : pix_in_b;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) begin m_cnt[c] = 0; m_pix[c] = 0; m_pix_k[c] = 1; end
         m_rdata = 0; run_w = 0; run_r = 0; pend_w = 0; pend_r = 0;
      end else begin
         bit g [3];
         int wc, wi;
         wc = -1; wi = 0;
         for (int c = 0; c < 3; c++) g[c] = 0;
         if (pend_w || pend_r) begin
            int a;
            a = int'(host_addr);
            if (a == 27) begin
               for (int c = 0; c < 3; c++) m_cnt[c] = 0;
            end else if (a >= 28 && a <= 30) begin
               int c;
               c = a - 28;
               if (m_cnt[c] < 256) begin
                  g[c] = 1;
                  if (pend_w) begin wc = c; wi = m_cnt[c]; end
                  else m_rdata = m_ram[c][m_cnt[c]];
                  m_cnt[c]++;
               end
            end
         end
         for (int c = 0; c < 3; c++) begin
            if (!g[c]) begin
               m_pix[c]   = m_ram[c][pix_sel(c)];
               m_pix_k[c] = m_known[c][pix_sel(c)];
            end
         end
         if (wc >= 0) begin m_ram[wc][wi] = host_wdata; m_known[wc][wi] = 1; end
         run_w  = (!host_cs_n && !host_wr_n) ? run_w + 1 : 0;
         run_r  = (!host_cs_n && !host_rd_n) ? run_r + 1 : 0;
         pend_w = (run_w == 2);
         pend_r = (run_r == 2);
      end
   end

   // ---------------- per-clock comparison ----------------
   task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cmp("R5 host_rdata", host_rdata, m_rdata);
         if (m_pix_k[0]) cmp("R7,R8 pix_out_r", pix_out_r, m_pix[0]);
         if (m_pix_k[1]) cmp("R7,R8 pix_out_g", pix_out_g, m_pix[1]);
         if (m_pix_k[2]) cmp("R7,R8 pix_out_b", pix_out_b, m_pix[2]);
      end
   end

   // free-running pixel indices
   initial begin
      forever begin
         @(negedge clk);
         pix_in_r = pix_in_r + 8'd37;
         pix_in_g = pix_in_g + 8'd11;
         pix_in_b = pix_in_b - 8'd5;
      end
   end

   function automatic logic [7:0] pat(input int c, input int i);
      case (c)
         0:       return 8'(i) ^ 8'h5A;
         1:       return ~8'(i);
         default: return 8'(i * 3 + 1);
      endcase
   endfunction

   task automatic host_op(input int a, input bit w, input logic [7:0] d, input int hold);
      @(negedge clk);
      host_addr = 5'(a); host_wdata = d; host_cs_n = 0;
      if (w) host_wr_n = 0; else host_rd_n = 0;
      repeat (hold) @(negedge clk);
      host_cs_n = 1; host_rd_n = 1; host_wr_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state at the ports
      cmp("R9 reset rdata", host_rdata, 8'h00);
      cmp("R9 reset pix_r", pix_out_r, 8'h00);
      cmp("R9 reset pix_b", pix_out_b, 8'h00);
      rst_n = 1;

      // R1 clear, R2/R4 interleaved load of all three tables with minimum write strobe
      host_op(27, 1, 8'h00, 2);
      for (int i = 0; i < 256; i++) begin
         host_op(28, 1, pat(0, i), 2);
         host_op(29, 1, pat(1, i), 2);
         host_op(30, 1, pat(2, i), 2);
      end
      // R3: overrun write ignored; R6: unused address ignored
      host_op(28, 1, 8'hFF, 2);
      host_op(31, 1, 8'hEE, 2);
      repeat (300) @(negedge clk);

      // R1 clear by read strobe, then read back red, interleaving green (R4)
      host_op(27, 0, 8'h00, 5);
      for (int i = 0; i < 256; i++) begin
         host_op(28, 0, 8'h00, 5);
         cmp("R2,R5 red readback", host_rdata, pat(0, i));
         if (i < 4) begin
            host_op(29, 0, 8'h00, 5);
            cmp("R4 green interleaved readback", host_rdata, pat(1, i));
         end
      end
      // R3: exhausted pointer, rdata holds last value
      host_op(28, 0, 8'h00, 5);
      cmp("R3 read past end ignored", host_rdata, pat(0, 255));

      // R6: two-clock write strobe lands exactly once
      host_op(27, 1, 8'h00, 2);
      host_op(28, 1, 8'hC3, 2);
      host_op(28, 0, 8'h00, 5);
      cmp("R6 one access per strobe", host_rdata, pat(0, 1));
      host_op(27, 1, 8'h00, 2);
      host_op(28, 0, 8'h00, 5);
      cmp("R6 short write landed", host_rdata, 8'hC3);

      // R9: asynchronous reset mid-run, pointer returns to zero
      @(posedge clk); #2;
      rst_n = 0; #1;
      cmp("R9 async rdata", host_rdata, 8'h00);
      cmp("R9 async pix_g", pix_out_g, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1;
      host_op(28, 0, 8'h00, 5);
      cmp("R9 pointer cleared by reset", host_rdata, 8'hC3);
      host_op(30, 0, 8'h00, 5);
      cmp("R9 blue pointer cleared", host_rdata, pat(2, 0));
      repeat (20) @(negedge clk);
      finish_run();
   end
endmodule